// File: doc/BRIEF.md
# Quadrature Bus Clock Generator

This block takes one fast oscillator clock and produces two bus phase clocks of equal frequency, E and Q, for an 8-bit processor whose external bus timing needs two clocks a quarter period apart. With the default setting, a 4 MHz oscillator gives two 1 MHz square waves. Q always leads E by one oscillator period (250 ns), so each bus cycle contains a distinct quarter for every combination of the two levels.

Internally, a step timer paces a two-bit phase sequencer. The sequencer walks the output pair (Q,E) through 00, 10, 11, 01 and then repeats. Both outputs are taken directly from flip-flops clocked by the oscillator, so no gate sits between a register and a pin, and neither output can glitch. The parameter `STEP_CYCLES` sets how many oscillator cycles each quarter lasts. The default value of 1 gives the divide-by-four. A synchronous active-low reset parks both outputs low.

Top module: `qclk_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk_osc`, both `q_clk` and `e_clk` are 0 after that edge.
- R2: After reset is released, `q_clk` is the first output to rise, `STEP_CYCLES` edges after release, and `e_clk` is still 0 at that point.
- R3: The pair (`q_clk`,`e_clk`) follows the fixed cycle 00 → 10 → 11 → 01 → 00 and never takes any other step.
- R4: Each state of the pair is held for exactly `STEP_CYCLES` oscillator cycles. With the default of 1, that is one 250 ns input period at 4 MHz.
- R5: Both outputs have a period of exactly 4×`STEP_CYCLES` input cycles, which is divide-by-four with the default setting and never divide-by-eight.
- R6: Each output is high for 2×`STEP_CYCLES` cycles and low for 2×`STEP_CYCLES` cycles, giving a 50 % duty cycle.
- R7: Q leads E. `e_clk` rises only while `q_clk` is high, and falls only while `q_clk` is low.
- R8: At most one of the two outputs changes on any single input edge.
- R9: Asserting reset in the middle of a run, in any phase, returns the pair to 00, and the sequence restarts from R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Fast oscillator clock (nominally 4 MHz) |
| rst_n | input | 1 | Synchronous reset, active low |
| e_clk | output | 1 | Bus phase clock E, registered |
| q_clk | output | 1 | Quadrature clock Q, leads E by one quarter period, registered |

## Verification
The checker watches the outputs on every oscillator edge for four properties: that each step is a legal successor in the cycle, that the pair holds for exactly `STEP_CYCLES` edges, that at most one output toggles per edge, and that E changes only while Q is at the matching level. It also checks that reset drives both outputs to zero. The bench's scenarios measure the properties that depend on an absolute count since reset. These are which output rises first after release, the full period, the high time of each output, and the restart after resets applied in every phase. The bench computes the expected phase from the number of edges since release and compares against both the default configuration and a slowed one.

// File: rtl/qclk_pkg.sv
// Package qclk_pkg
// Shared phase type and the mapping from sequencer phase to output levels.
// Assumes four phases per bus cycle, indexed 0..3 in time order.
package qclk_pkg;

    localparam int PHASE_COUNT = 4;
    localparam int PHASE_W     = $clog2(PHASE_COUNT);

    typedef logic [PHASE_W-1:0] phase_t;

    // Output pair {q, e} for a given phase index.
    function automatic logic [1:0] phase_to_qe(input phase_t ph);
        logic [1:0] qe;
        case (ph)
            2'd0:    qe = 2'b00;
            2'd1:    qe = 2'b10;
            2'd2:    qe = 2'b11;
            default: qe = 2'b01;
        endcase
        return qe;
    endfunction

    // Legal successor of an output pair {q, e} in the quadrature cycle.
    function automatic logic [1:0] qe_successor(input logic [1:0] qe);
        logic [1:0] nx;
        case (qe)
            2'b00:   nx = 2'b10;
            2'b10:   nx = 2'b11;
            2'b11:   nx = 2'b01;
            default: nx = 2'b00;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/qclk_step_timer.sv
// Module qclk_step_timer
// Issues an advance pulse once every STEP_CYCLES oscillator cycles.
// Assumes STEP_CYCLES >= 1. When STEP_CYCLES is 1 the pulse stays high.
// Counting restarts from zero on a synchronous active-low reset.
module qclk_step_timer #(
    parameter int STEP_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Pulse on the last count of each quarter.
    always_comb tick = (cnt == LAST);

    // Count oscillator cycles within the current quarter.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/qclk_phase_seq.sv
// Module qclk_phase_seq
// Holds the current phase index (0..3) and advances it by one on each tick.
// The index wraps from 3 back to 0. The next value is exported so that the
// output stage can register its decode with no added latency.
module qclk_phase_seq
    import qclk_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    output phase_t phase_cur,
    output phase_t phase_nxt
);

    // Next phase: step forward on tick, otherwise hold.
    always_comb phase_nxt = tick ? phase_t'(phase_cur + 1'b1) : phase_cur;

    // Phase register, parked at phase 0 in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_cur <= '0;
        else        phase_cur <= phase_nxt;
    end

endmodule

// File: rtl/qclk_out_reg.sv
// Module qclk_out_reg
// Registers the decoded output levels so that both bus clocks come straight
// from flip-flops. Assumes phase_nxt is the value the sequencer loads at the
// same edge, which keeps the outputs aligned with the phase register.
module qclk_out_reg
    import qclk_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_t phase_nxt,
    output logic   q_o,
    output logic   e_o
);
    logic [1:0] qe_d;

    // Decode the levels for the coming phase.
    always_comb qe_d = phase_to_qe(phase_nxt);

    // Output flip-flops, both low in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= 1'b0;
            e_o <= 1'b0;
        end else begin
            q_o <= qe_d[1];
            e_o <= qe_d[0];
        end
    end

endmodule

// File: rtl/qclk_gen.sv
// Module qclk_gen (top)
// Quadrature bus clock generator. It divides clk_osc by 4*STEP_CYCLES into
// two square waves, with Q leading E by STEP_CYCLES oscillator periods.
// Assumes a free-running oscillator and a reset synchronous to it.
module qclk_gen
    import qclk_pkg::*;
#(
    parameter int STEP_CYCLES = 1
) (
    input  logic clk_osc,
    input  logic rst_n,
    output logic e_clk,
    output logic q_clk
);
    logic   tick;
    phase_t phase_cur;
    phase_t phase_nxt;

    qclk_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
        .clk   (clk_osc),
        .rst_n (rst_n),
        .tick  (tick)
    );

    qclk_phase_seq u_seq (
        .clk       (clk_osc),
        .rst_n     (rst_n),
        .tick      (tick),
        .phase_cur (phase_cur),
        .phase_nxt (phase_nxt)
    );

    qclk_out_reg u_out (
        .clk       (clk_osc),
        .rst_n     (rst_n),
        .phase_nxt (phase_nxt),
        .q_o       (q_clk),
        .e_o       (e_clk)
    );

endmodule

// File: rtl/qclk_gen_chk.sv
// Module qclk_gen_chk
// Checker bound to qclk_gen. It observes only the output pins and reset, and
// checks the cycle order, the hold time per quarter, the phase lead and the
// reset value on every oscillator edge.
module qclk_gen_chk
    import qclk_pkg::*;
#(
    parameter int STEP_CYCLES = 1
) (
    input logic clk,
    input logic rst_n,
    input logic q_clk,
    input logic e_clk
);
    localparam int HOLD_W = $clog2(STEP_CYCLES + 2) + 1;
    localparam logic [HOLD_W-1:0] HOLD_MAX = {HOLD_W{1'b1}};

    logic [1:0]        prev_qe;
    logic [HOLD_W-1:0] hold_cnt;

    // Track the last observed pair and how many edges it has been held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_qe  <= 2'b00;
            hold_cnt <= '0;
        end else begin
            prev_qe <= {q_clk, e_clk};
            if ({q_clk, e_clk} != prev_qe) hold_cnt <= HOLD_W'(1);
            else if (hold_cnt != HOLD_MAX) hold_cnt <= hold_cnt + 1'b1;
        end
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (!q_clk && !e_clk));

    // R3
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({q_clk, e_clk}) |-> ({q_clk, e_clk} == qe_successor($past({q_clk, e_clk}))));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({q_clk, e_clk} != prev_qe) |-> (hold_cnt == HOLD_W'(STEP_CYCLES)));

    // R7
    lead_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(e_clk) |-> q_clk);

    // R7
    lag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(e_clk) |-> !q_clk);

    // R8
    single_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({q_clk, e_clk} ^ $past({q_clk, e_clk})) <= 1);

endmodule

bind qclk_gen qclk_gen_chk #(.STEP_CYCLES(STEP_CYCLES)) u_qclk_chk (
    .clk   (clk_osc),
    .rst_n (rst_n),
    .q_clk (q_clk),
    .e_clk (e_clk)
);

// File: tb/qclk_gen_bench.sv
// Bench for qclk_gen. It sweeps reset release and mid-run resets across every
// phase, for the default configuration and for a slowed one with a quarter of
// three cycles. Expected levels come from the edge count since release.
module qclk_gen_bench;
    localparam int SLOW_STEP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic e_a, q_a, e_b, q_b;

    int n_edges = 0;
    int checks = 0;
    int fails = 0;
    logic midrun = 1'b0;

    int pq = 0, pe = 0, last_qrise = -1, last_erise = -1;

    always #5 clk = ~clk;

    // Count edges since reset release, as seen by the design.
    always @(posedge clk) n_edges <= rst_n ? n_edges + 1 : 0;

    qclk_gen u_qclk_gen (
        .clk_osc (clk), .rst_n (rst_n), .e_clk (e_a), .q_clk (q_a)
    );

    qclk_gen #(.STEP_CYCLES(SLOW_STEP)) u_qclk_gen_slow (
        .clk_osc (clk), .rst_n (rst_n), .e_clk (e_b), .q_clk (q_b)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at edge %0d: actual %0d expected %0d", req, n_edges, act, exp);
        end
    endtask

    function automatic int exp_qe(input int n, input int step);
        int ph;
        ph = (n / step) % 4;
        return (ph == 1 || ph == 2) ? ((ph == 2) ? 3 : 2) : ((ph == 3) ? 1 : 0);
    endfunction

    // Check both instances at the falling edge.
    task automatic sample();
        int qe_a, qe_b, chg;
        qe_a = {30'd0, q_a, e_a};
        qe_b = {30'd0, q_b, e_b};
        if (n_edges == 0) begin
            chk(qe_a == 0, "R1", qe_a, 0);
            chk(qe_b == 0, "R1", qe_b, 0);
            last_qrise = -1;
            last_erise = -1;
        end else begin
            if (n_edges == 1) chk(qe_a == 2, midrun ? "R9" : "R2", qe_a, 2);
            else              chk(qe_a == exp_qe(n_edges, 1), "R3", qe_a, exp_qe(n_edges, 1));
            if (n_edges == SLOW_STEP) chk(qe_b == 2, "R2", qe_b, 2);
            chk(qe_b == exp_qe(n_edges, SLOW_STEP), "R4", qe_b, exp_qe(n_edges, SLOW_STEP));
            if (n_edges >= 2) begin
                chg = ((int'(q_a) != pq) ? 1 : 0) + ((int'(e_a) != pe) ? 1 : 0);
                // R4 R8: default quarter is one cycle, one output changes per edge
                chk(chg == 1, "R8", chg, 1);
            end
            if (pe == 0 && e_a) begin
                chk(q_a == 1'b1, "R7", int'(q_a), 1);
                last_erise = n_edges;
            end
            if (pe == 1 && !e_a) begin
                chk(q_a == 1'b0, "R7", int'(q_a), 0);
                if (last_erise >= 0) chk(n_edges - last_erise == 2, "R6", n_edges - last_erise, 2);
            end
            if (pq == 0 && q_a) begin
                if (last_qrise >= 0) chk(n_edges - last_qrise == 4, "R5", n_edges - last_qrise, 4);
                last_qrise = n_edges;
            end
            if (pq == 1 && !q_a && last_qrise >= 0)
                chk(n_edges - last_qrise == 2, "R6", n_edges - last_qrise, 2);
        end
        pq = int'(q_a);
        pe = int'(e_a);
    endtask

    task automatic run(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            sample();
        end
    endtask

    initial begin
        rst_n = 1'b0;
        run(3);
        rst_n = 1'b1;
        run(40);
        // R9: reset in every phase of both instances
        for (int k = 1; k <= 12; k++) begin
            midrun = 1'b1;
            rst_n = 1'b0;
            run(2);
            rst_n = 1'b1;
            run(k + 16);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule